// File: doc/BRIEF.md
# Dual-Order Wraparound Burst Address Generator

This block produces the low address bits for a four-beat burst into a pipelined memory. When an address strobe opens a cycle, the controller pulses `load` and presents the two low bits of the starting address. On each later clock where `step` is high, the block moves to the next beat of a four-entry wraparound sequence. When `step` is low, the block keeps the current beat.

A static strap input, `order_xor`, selects one of two orderings. The linear order adds the beat count to the start value modulo four. The interleaved order XORs the start value with the beat count. The block keeps only the start value and a beat index. The burst address is formed from these two registers through a small combinational map, so it is valid in the cycle after the clock edge that loaded or advanced the counter.

Top module: `burst_wrap_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, the start register and the beat index are cleared, so `burst_addr` and `beat_idx` both read 0 after that edge.
- R2: When `load` is high at a rising edge, `beat_idx` becomes 0 and `burst_addr` becomes the `start_addr` value sampled at that edge, in either ordering.
- R3: When `load` and `step` are both high at the same edge, the load wins: `beat_idx` is 0 after the edge and no advance is taken.
- R4: When `step` is high and `load` is low at an edge, `beat_idx` becomes the previous beat index plus one, modulo 4.
- R5: When `step` and `load` are both low at an edge, `beat_idx` and `burst_addr` keep their values.
- R6: With `order_xor` = 0 (linear), `burst_addr` equals (start + `beat_idx`) modulo 4. For example, start 1 gives 1, 2, 3, 0.
- R7: With `order_xor` = 1 (interleaved), `burst_addr` equals start XOR `beat_idx`. For example, start 2 gives 2, 3, 0, 1.
- R8: After four advances with no load in between, `beat_idx` returns to 0 and `burst_addr` returns to the start value. The four beats in between visit every 2-bit address exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Begin a burst: capture `start_addr` and clear the beat index |
| start_addr | input | 2 | Low address bits of the first beat |
| step | input | 1 | Advance to the next beat when high |
| order_xor | input | 1 | Ordering strap: 0 selects linear, 1 selects interleaved |
| burst_addr | output | 2 | Low address bits of the current beat |
| beat_idx | output | 2 | Current beat number within the burst, 0 to 3 |

## Verification
The bench sweeps both orderings against every start value. It runs a burst of five advances with hold cycles mixed in, so it covers the wrap past the fourth beat as well as every start. A linear sequence that carried into a third bit, or an interleaved sequence built with an adder, would miss the first beat where the two orderings differ. The bench also issues a load together with an advance, which catches a design that gives priority to the advance: that design would begin the new burst one beat late. It reloads in the middle of a burst to confirm that the beat index starts again at zero and does not carry over the remaining count.

// File: rtl/burst_pkg.sv
// Package: shared ordering type for the burst address generator.
// Assumes: the strap value 1 means XOR (interleaved) ordering.
package burst_pkg;
    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;
endpackage

// File: rtl/burst_start_reg.sv
// Holds the first-beat address of the current burst.
// Assumes: load is a single-cycle pulse qualified by the caller; rst_n is synchronous.
module burst_start_reg #(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_in,
    output logic [ADDR_W-1:0] start_q
);
    // Capture the start bits on load; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (load) begin
            start_q <= start_in;
        end
    end
endmodule

// File: rtl/burst_beat_ctr.sv
// Beat counter: cleared by load, advanced by step, wraps modulo 2**ADDR_W.
// Assumes: load takes priority over step in the same cycle.
module burst_beat_ctr #(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [ADDR_W-1:0] beat_q
);
    logic [ADDR_W-1:0] beat_next;

    // Choose the next beat: reload to zero, advance with wrap, or hold.
    always_comb begin
        if (load) begin
            beat_next = '0;
        end else if (step) begin
            beat_next = beat_q + 1'b1;
        end else begin
            beat_next = beat_q;
        end
    end

    // Register the beat count; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_next;
        end
    end
endmodule

// File: rtl/burst_seq_map.sv
// Maps the start value and the beat index to a burst address in the selected order.
// Assumes: the ordering strap is static while a burst is in progress.
module burst_seq_map
    import burst_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  order_e            order,
    input  logic [ADDR_W-1:0] start_q,
    input  logic [ADDR_W-1:0] beat_q,
    output logic [ADDR_W-1:0] addr_out
);
    logic [ADDR_W-1:0] lin_addr;
    logic [ADDR_W-1:0] xor_addr;

    // Work out both orderings and select one with the strap.
    always_comb begin
        lin_addr = start_q + beat_q;
        xor_addr = start_q ^ beat_q;
        addr_out = (order == ORDER_XOR) ? xor_addr : lin_addr;
    end
endmodule

// File: rtl/burst_wrap_gen.sv
// Top module: generates the wraparound burst address in linear or interleaved order.
// Assumes: load marks the strobe-started cycle; order_xor is a static strap.
module burst_wrap_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              step,
    input  logic              order_xor,
    output logic [ADDR_W-1:0] burst_addr,
    output logic [ADDR_W-1:0] beat_idx
);
    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] beat_q;
    order_e            order;

    assign order    = order_e'(order_xor);
    assign beat_idx = beat_q;

    burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .start_in (start_addr),
        .start_q  (start_q)
    );

    burst_beat_ctr #(.ADDR_W(ADDR_W)) u_beat (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .beat_q (beat_q)
    );

    burst_seq_map #(.ADDR_W(ADDR_W)) u_map (
        .order    (order),
        .start_q  (start_q),
        .beat_q   (beat_q),
        .addr_out (burst_addr)
    );
endmodule

// File: rtl/burst_wrap_gen_chk.sv
// Checker: temporal properties of the burst generator, seen only at its ports.
// Assumes: bound to every instance of burst_wrap_gen.
module burst_wrap_gen_chk #(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic [ADDR_W-1:0] start_addr,
    input logic              step,
    input logic              order_xor,
    input logic [ADDR_W-1:0] burst_addr,
    input logic [ADDR_W-1:0] beat_idx
);
    // R1: an edge with reset low leaves the outputs at zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (beat_idx == '0) && (burst_addr == '0));

    assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat_idx == '0) && (burst_addr == $past(start_addr)));

    assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && step) |=> (beat_idx == '0));

    assert_step_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step) |=> (beat_idx == $past(beat_idx) + 1'b1));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(beat_idx));

    // R6: (addr - beat) stays equal to the start value between loads
    assert_linear_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!load) && $past(!order_xor) && !order_xor)
        |-> (ADDR_W'(burst_addr - beat_idx) == ADDR_W'($past(burst_addr) - $past(beat_idx))));

    // R7: (addr ^ beat) stays equal to the start value between loads
    assert_xor_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!load) && $past(order_xor) && order_xor)
        |-> ((burst_addr ^ beat_idx) == ($past(burst_addr) ^ $past(beat_idx))));
endmodule

bind burst_wrap_gen burst_wrap_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .start_addr (start_addr),
    .step       (step),
    .order_xor  (order_xor),
    .burst_addr (burst_addr),
    .beat_idx   (beat_idx)
);

// File: tb/tb_burst_wrap_gen.sv
module tb_burst_wrap_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic [1:0] start_addr = 2'd0;
    logic       step = 1'b0;
    logic       order_xor = 1'b0;
    logic [1:0] burst_addr;
    logic [1:0] beat_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int exp_start = 0;
    int exp_beat  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_wrap_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .start_addr (start_addr),
        .step       (step),
        .order_xor  (order_xor),
        .burst_addr (burst_addr),
        .beat_idx   (beat_idx)
    );

    function automatic int model_addr(int s, int b, bit x);
        return x ? (s ^ b) : ((s + b) % 4);
    endfunction

    task automatic chk(string req, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Apply inputs at a falling edge, let one rising edge pass, then sample
    task automatic cyc(bit ld, int sa, bit st);
        load       = ld;
        start_addr = 2'(sa);
        step       = st;
        @(negedge clk);
        if (ld) begin
            exp_start = sa;
            exp_beat  = 0;
        end else if (st) begin
            exp_beat = (exp_beat + 1) % 4;
        end
        load = 1'b0;
        step = 1'b0;
    endtask

    task automatic chk_state(string req);
        chk({req, " beat"}, int'(beat_idx), exp_beat);
        chk({req, " addr"}, int'(burst_addr), model_addr(exp_start, exp_beat, order_xor));
    endtask

    initial begin
        @(negedge clk);
        step = 1'b1;
        load = 1'b1;
        start_addr = 2'd3;
        @(negedge clk);
        @(negedge clk);
        // R1: reset clears both registers
        chk("R1 beat", int'(beat_idx), 0);
        chk("R1 addr", int'(burst_addr), 0);
        load = 1'b0;
        step = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        for (int m = 0; m < 2; m++) begin
            order_xor = m[0];
            @(negedge clk);
            for (int s = 0; s < 4; s++) begin
                cyc(1'b1, s, 1'b0);
                chk_state("R2 load");
                for (int k = 1; k <= 5; k++) begin
                    cyc(1'b0, 0, 1'b1);
                    chk_state(m ? "R7 xor step" : "R6 linear step");
                    chk("R4 beat", int'(beat_idx), k % 4);
                    if (k == 2) begin
                        cyc(1'b0, 3 - s, 1'b0);
                        chk_state("R5 hold");
                    end
                    if (k == 4) begin
                        // R8: wrapped back to the start
                        chk("R8 wrap addr", int'(burst_addr), s);
                    end
                end
                // R3: load together with step starts a new burst at beat 0
                cyc(1'b1, (s + 1) % 4, 1'b1);
                chk("R3 beat", int'(beat_idx), 0);
                chk("R3 addr", int'(burst_addr), (s + 1) % 4);
                cyc(1'b0, 0, 1'b1);
                chk_state("R3 follow");
            end
            // R8: one full burst visits every address once
            begin
                bit [3:0] seen = '0;
                cyc(1'b1, 1, 1'b0);
                for (int k = 0; k < 4; k++) begin
                    seen[burst_addr] = 1'b1;
                    cyc(1'b0, 0, 1'b1);
                end
                chk("R8 coverage", int'(seen), 15);
            end
        end
        // Fixed examples from the requirements
        order_xor = 1'b0;
        cyc(1'b1, 1, 1'b0);
        cyc(1'b0, 0, 1'b1);
        cyc(1'b0, 0, 1'b1);
        chk("R6 example", int'(burst_addr), 3);
        order_xor = 1'b1;
        cyc(1'b1, 2, 1'b0);
        cyc(1'b0, 0, 1'b1);
        cyc(1'b0, 0, 1'b1);
        cyc(1'b0, 0, 1'b1);
        chk("R7 example", int'(burst_addr), 1);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule